// File: doc/BRIEF.md
# Grouped Interrupt Expansion Controller

This block gathers a large number of peripheral interrupt pulses into a handful of CPU-level request lines. Sources are organised as groups of lines (12 groups of 8 by default). Each line latches its pulse into a sticky flag and has its own enable bit. A group raises its CPU line only when it has an enabled pending flag and its acknowledge bit is clear. Forwarding sets that acknowledge bit, which holds the group off until software clears it. A few direct lines skip the grouping and are passed straight through to further CPU lines.

When the CPU accepts an interrupt, it presents an accept strobe with a kind code. The block then returns a vector from a writable table holding one entry per source, and clears the flag of the chosen multiplexed source. It then stays busy for a fixed window that models the vector fetch and the register save. NMI and trap are always serviceable. While the controller is disabled, their vectors come from fixed constants; while it is enabled, they come from the writable table. Software reaches the controls and the table through a simple word-addressed write/read bus.

Top module: `grpint_ctrl`

## Requirements
- R1: After reset the controller is disabled (address 0, bit 0 reads 0), every line enable and every acknowledge bit reads 0, all CPU lines are low and `busy` is low.
- R2: A one-cycle pulse on `src_pulse[g*8+l]` sets a sticky flag. The flag reads back at address 16+g in bit 8+l, with that group's enables in bits 7:0.
- R3: While enabled, a group with at least one pending and enabled flag and a clear acknowledge bit raises `cpu_irq[g]` for exactly one cycle, one clock after the condition holds. The same edge sets acknowledge bit g (address 1). No further pulse comes from that group while the bit stays set.
- R4: Writing 1 to bit g of address 1 clears acknowledge bit g. If the group is still pending, `cpu_irq[g]` pulses again one clock later.
- R5: While disabled, no group line rises and accepts of kind 0 (multiplexed) or 1 (direct) are ignored: no vector, no busy, flags unchanged.
- R6: An accept of kind 0 picks the pending enabled source with the lowest group, then the lowest line. It returns table entry g*8+l and clears that flag.
- R7: A source pulse arriving on the same edge that its flag is cleared by an accept leaves the flag set.
- R8: Accepts of kind 2 (NMI) and kind 3 (trap) are always served. While disabled they return `ROM_NMI`/`ROM_TRAP`; while enabled they return table entries 100 and 101.
- R9: Each served accept raises `vec_valid` for one cycle and `busy` for 9 cycles; accepts during `busy` are ignored.
- R10: `dir_in[k]` appears on `cpu_irq[12+k]` one clock later. A direct accept (kind 1, index k) while enabled returns table entry 96+k.
- R11: A write to address 128+i replaces table entry i at any time, and the next fetch of that entry returns the new value.
- R12: A kind 0 accept with nothing pending and enabled is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | 96 | Peripheral interrupt pulses, index g*8+l |
| dir_in | input | 4 | Direct (non-grouped) interrupt lines |
| cpu_irq | output | 16 | CPU request lines: groups in 11:0, direct lines above |
| acc_req | input | 1 | CPU accepts an interrupt this cycle |
| acc_kind | input | 2 | 0 multiplexed, 1 direct, 2 NMI, 3 trap |
| acc_idx | input | 2 | Direct line index for kind 1 |
| vec_valid | output | 1 | Vector on `vec_data` is valid this cycle |
| vec_data | output | 32 | Returned vector |
| busy | output | 1 | Fetch/save window active |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 8 | Bus word address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |

## Verification
A source pulse is latched by the edge it straddles, and the group line answers one edge later. An accept returns its vector and raises `busy` on the edge that samples it, and `busy` then lasts exactly nine sampled cycles. Bus writes act on their edge, and read data appears one edge after the address is set. The bench drives inputs on falling edges and samples on the next falling edge after the counted number of rising edges. It counts busy and vector-valid cycles over fixed windows rather than waiting for them, and it reads flags and acknowledge bits back over the bus between one stimulus and the next.

// File: rtl/grpint_pkg.sv
package grpint_pkg;
  typedef enum logic [1:0] {
    ACC_MASK   = 2'd0,
    ACC_DIRECT = 2'd1,
    ACC_NMI    = 2'd2,
    ACC_TRAP   = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/grpint_lines.sv
module grpint_lines #(
  parameter int NGRP  = 12,
  parameter int NLINE = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ctl_en,
  input  logic [NGRP*NLINE-1:0] set_i,
  input  logic [NGRP*NLINE-1:0] clr_i,
  input  logic [NGRP-1:0]       en_we,
  input  logic [NLINE-1:0]      en_wdata,
  input  logic [NGRP-1:0]       ack_w1c,
  output logic [NGRP*NLINE-1:0] flag_o,
  output logic [NGRP*NLINE-1:0] en_o,
  output logic [NGRP-1:0]       ack_o,
  output logic [NGRP-1:0]       irq_o
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [NLINE-1:0] flag_r;
    logic [NLINE-1:0] en_r;
    logic             ack_r;
    logic             irq_r;
    logic             fwd;

    // forward only while enabled, pending and not yet acknowledged
    assign fwd = ctl_en && (|(flag_r & en_r)) && !ack_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        flag_r <= '0;
        en_r   <= '0;
        ack_r  <= 1'b0;
        irq_r  <= 1'b0;
      end else begin
        // set dominates clear
        flag_r <= (flag_r & ~clr_i[g*NLINE +: NLINE]) | set_i[g*NLINE +: NLINE];
        if (en_we[g]) en_r <= en_wdata;
        ack_r  <= (ack_r & ~ack_w1c[g]) | fwd;
        irq_r  <= fwd;
      end
    end

    assign flag_o[g*NLINE +: NLINE] = flag_r;
    assign en_o[g*NLINE +: NLINE]   = en_r;
    assign ack_o[g]                 = ack_r;
    assign irq_o[g]                 = irq_r;
  end
endmodule

// File: rtl/grpint_pick.sv
module grpint_pick #(
  parameter int N  = 96,
  parameter int IW = 7
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  // flat index g*NLINE+l: lowest index means lowest group, then lowest line
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/grpint_vtable.sv
module grpint_vtable #(
  parameter int DEPTH = 102,
  parameter int AW    = 7,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/grpint_ctrl.sv
module grpint_ctrl
  import grpint_pkg::*;
#(
  parameter int NGRP     = 12,
  parameter int NLINE    = 8,
  parameter int NDIR     = 4,
  parameter int DIR_IW   = 2,
  parameter int VEC_W    = 32,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int BUSY_CYC = 9,
  parameter logic [VEC_W-1:0] ROM_NMI  = 32'h0000_0040,
  parameter logic [VEC_W-1:0] ROM_TRAP = 32'h0000_0044
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NGRP*NLINE-1:0]  src_pulse,
  input  logic [NDIR-1:0]        dir_in,
  output logic [NGRP+NDIR-1:0]   cpu_irq,
  input  logic                   acc_req,
  input  logic [1:0]             acc_kind,
  input  logic [DIR_IW-1:0]      acc_idx,
  output logic                   vec_valid,
  output logic [VEC_W-1:0]       vec_data,
  output logic                   busy,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata
);
  localparam int NSRC      = NGRP * NLINE;
  localparam int NVEC      = NSRC + NDIR + 2;
  localparam int VIW       = $clog2(NVEC);
  localparam int SIW       = $clog2(NSRC);
  localparam int CW        = $clog2(BUSY_CYC + 1);
  localparam int A_CTRL    = 0;
  localparam int A_ACK     = 1;
  localparam int A_GRP     = 16;
  localparam int A_VT      = 128;
  localparam int NMI_SLOT  = NSRC + NDIR;
  localparam int TRAP_SLOT = NSRC + NDIR + 1;

  logic                 ctl_en;
  logic [NGRP-1:0]      ack_q;
  logic [NGRP-1:0]      grp_irq;
  logic [NDIR-1:0]      dir_q;
  logic [NSRC-1:0]      flag_v, en_v, clr_v;
  logic [NGRP-1:0]      en_we, ack_w1c;
  logic [CW-1:0]        busy_cnt;
  logic                 pick_hit;
  logic [SIW-1:0]       pick_idx;
  logic                 go, use_rom, rom_q, vvalid_q;
  logic [VIW-1:0]       sel;
  logic [VEC_W-1:0]     rom_val, romv_q, vt_q;
  logic                 vt_we;
  logic [VIW-1:0]       vt_waddr;
  logic [DATA_W-1:0]    rd_next;

  // ---------------- bus decode ----------------
  assign ack_w1c = (bus_wr && bus_addr == ADDR_W'(A_ACK)) ? bus_wdata[NGRP-1:0] : '0;

  for (genvar g = 0; g < NGRP; g++) begin : g_enwe
    assign en_we[g] = bus_wr && (bus_addr == ADDR_W'(A_GRP + g));
  end

  assign vt_we    = bus_wr && (bus_addr >= ADDR_W'(A_VT)) &&
                    ((bus_addr - ADDR_W'(A_VT)) < ADDR_W'(NVEC));
  assign vt_waddr = VIW'(bus_addr - ADDR_W'(A_VT));

  always_ff @(posedge clk) begin
    if (rst) ctl_en <= 1'b0;
    else if (bus_wr && bus_addr == ADDR_W'(A_CTRL)) ctl_en <= bus_wdata[0];
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(A_CTRL)) rd_next[0] = ctl_en;
    if (bus_addr == ADDR_W'(A_ACK))  rd_next[NGRP-1:0] = ack_q;
    for (int g = 0; g < NGRP; g++) begin
      if (bus_addr == ADDR_W'(A_GRP + g)) begin
        rd_next[NLINE-1:0]       = en_v[g*NLINE +: NLINE];
        rd_next[2*NLINE-1:NLINE] = flag_v[g*NLINE +: NLINE];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  // ---------------- group lines ----------------
  grpint_lines #(.NGRP(NGRP), .NLINE(NLINE)) u_lines (
    .clk      (clk),
    .rst      (rst),
    .ctl_en   (ctl_en),
    .set_i    (src_pulse),
    .clr_i    (clr_v),
    .en_we    (en_we),
    .en_wdata (bus_wdata[NLINE-1:0]),
    .ack_w1c  (ack_w1c),
    .flag_o   (flag_v),
    .en_o     (en_v),
    .ack_o    (ack_q),
    .irq_o    (grp_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) dir_q <= '0;
    else     dir_q <= dir_in;
  end

  assign cpu_irq = {dir_q, grp_irq};

  // ---------------- accept path ----------------
  grpint_pick #(.N(NSRC), .IW(SIW)) u_pick (
    .req (flag_v & en_v),
    .hit (pick_hit),
    .idx (pick_idx)
  );

  always_comb begin
    go      = 1'b0;
    sel     = '0;
    use_rom = 1'b0;
    rom_val = '0;
    case (acc_kind_e'(acc_kind))
      ACC_MASK: begin
        go  = ctl_en && pick_hit;
        sel = VIW'(pick_idx);
      end
      ACC_DIRECT: begin
        go  = ctl_en && ({1'b0, acc_idx} < (DIR_IW + 1)'(NDIR));
        sel = VIW'(NSRC) + VIW'(acc_idx);
      end
      ACC_NMI: begin
        go      = 1'b1;
        sel     = VIW'(NMI_SLOT);
        use_rom = !ctl_en;
        rom_val = ROM_NMI;
      end
      default: begin
        go      = 1'b1;
        sel     = VIW'(TRAP_SLOT);
        use_rom = !ctl_en;
        rom_val = ROM_TRAP;
      end
    endcase
    if (!acc_req || busy_cnt != '0) go = 1'b0;
  end

  assign clr_v = (go && acc_kind == ACC_MASK) ? (NSRC'(1) << pick_idx) : '0;

  grpint_vtable #(.DEPTH(NVEC), .AW(VIW), .DW(VEC_W)) u_vt (
    .clk   (clk),
    .we    (vt_we),
    .waddr (vt_waddr),
    .wdata (bus_wdata[VEC_W-1:0]),
    .raddr (sel),
    .rdata (vt_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt <= '0;
      vvalid_q <= 1'b0;
      rom_q    <= 1'b0;
      romv_q   <= '0;
    end else begin
      vvalid_q <= go;
      if (go) begin
        busy_cnt <= CW'(BUSY_CYC);
        rom_q    <= use_rom;
        romv_q   <= rom_val;
      end else if (busy_cnt != '0) begin
        busy_cnt <= busy_cnt - 1'b1;
      end
    end
  end

  assign vec_valid = vvalid_q;
  assign vec_data  = rom_q ? romv_q : vt_q;
  assign busy      = (busy_cnt != '0);
endmodule

// File: rtl/grpint_ctrl_chk.sv
module grpint_ctrl_chk #(
  parameter int NGRP     = 12,
  parameter int NDIR     = 4,
  parameter int BUSY_CYC = 9,
  parameter int CW       = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ctl_en,
  input logic [NGRP-1:0]      ack,
  input logic [NGRP+NDIR-1:0] cpu_irq,
  input logic [NDIR-1:0]      dir_in,
  input logic [CW-1:0]        busy_cnt,
  input logic                 vec_valid
);
  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(rst) |-> (!ctl_en && ack == '0 && cpu_irq == '0 && busy_cnt == '0)); // R1

  AST_PULSE_NEEDS_CLEAR_ACK: assert property (@(posedge clk) disable iff (rst)
    (cpu_irq[NGRP-1:0] != '0) |-> ((cpu_irq[NGRP-1:0] & $past(ack)) == '0)); // R3

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (cpu_irq[NGRP-1:0] != '0) |=> ((cpu_irq[NGRP-1:0] & $past(cpu_irq[NGRP-1:0])) == '0)); // R3

  AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!ctl_en && !$past(ctl_en)) |-> (cpu_irq[NGRP-1:0] == '0)); // R5

  AST_FETCH_STARTS_BUSY: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> (busy_cnt == CW'(BUSY_CYC - 1))); // R9

  AST_NO_RELOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy_cnt != '0) |=> (busy_cnt == $past(busy_cnt) - 1'b1)); // R9

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy_cnt <= CW'(BUSY_CYC)); // R9

  AST_DIRECT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cpu_irq[NGRP +: NDIR] == $past(dir_in))); // R10
endmodule

bind grpint_ctrl grpint_ctrl_chk #(
  .NGRP(NGRP), .NDIR(NDIR), .BUSY_CYC(BUSY_CYC), .CW(CW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctl_en    (ctl_en),
  .ack       (ack_q),
  .cpu_irq   (cpu_irq),
  .dir_in    (dir_in),
  .busy_cnt  (busy_cnt),
  .vec_valid (vec_valid)
);

// File: tb/grpint_ctrl_test.sv
`timescale 1ns/1ps
module grpint_ctrl_test;
  localparam int NGRP = 12, NLINE = 8, NDIR = 4, NSRC = 96, NVEC = 102;
  localparam logic [31:0] RNMI = 32'h0000_0040, RTRAP = 32'h0000_0044;
  // rows: source a, source b, expected winner
  localparam int STIM [6][3] = '{'{5, 3, 3}, '{17, 9, 9}, '{8, 95, 8},
                                 '{41, 40, 40}, '{95, 0, 0}, '{64, 66, 64}};

  logic clk = 1'b0, rst = 1'b1;
  logic [NSRC-1:0] src_pulse = '0;
  logic [NDIR-1:0] dir_in = '0;
  logic [NGRP+NDIR-1:0] cpu_irq;
  logic acc_req = 1'b0;
  logic [1:0] acc_kind = 2'd0;
  logic [1:0] acc_idx = 2'd0;
  logic vec_valid, busy;
  logic [31:0] vec_data;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  grpint_ctrl uut (
    .clk(clk), .rst(rst), .src_pulse(src_pulse), .dir_in(dir_in), .cpu_irq(cpu_irq),
    .acc_req(acc_req), .acc_kind(acc_kind), .acc_idx(acc_idx), .vec_valid(vec_valid),
    .vec_data(vec_data), .busy(busy), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] tv(input int i);
    return 32'hA000_0000 | 32'(i);
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwrite(input int a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bread(input int a, output logic [31:0] d);
    @(negedge clk); bus_addr = 8'(a);
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic pulse_src(input int s);
    @(negedge clk); src_pulse[s] = 1'b1;
    @(negedge clk); src_pulse = '0;
  endtask

  task automatic accept(input logic [1:0] k, input int ix, input int set_src,
                        output logic v, output logic [31:0] d, output logic b);
    @(negedge clk); acc_req = 1'b1; acc_kind = k; acc_idx = 2'(ix);
    if (set_src >= 0) src_pulse[set_src] = 1'b1;
    @(negedge clk); acc_req = 1'b0; src_pulse = '0;
    v = vec_valid; d = vec_data; b = busy;
    repeat (9) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd, d;
    logic v, b;
    int nb, nv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cpu_irq == '0 && !busy && !vec_valid, "R1 outputs", 32'(cpu_irq), 0);
    bread(0, rd);  check(rd == 0, "R1 ctrl", rd, 0);
    bread(1, rd);  check(rd == 0, "R1 ack", rd, 0);
    bread(16, rd); check(rd == 0, "R1 group0", rd, 0);

    for (int i = 0; i < NVEC; i++) bwrite(128 + i, tv(i));
    for (int g = 0; g < NGRP; g++) bwrite(16 + g, 32'hFF);

    // disabled behaviour
    pulse_src(10);
    nb = 0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); if (cpu_irq[NGRP-1:0] != '0) nb++; end
    check(nb == 0, "R5 no group line while disabled", 32'(nb), 0);
    bread(17, rd); check(rd == 32'h04FF, "R2 sticky flag readback", rd, 32'h04FF);
    accept(2'd0, 0, -1, v, d, b); check(!v && !b, "R5 mask accept ignored", {30'd0, v, b}, 0);
    accept(2'd1, 1, -1, v, d, b); check(!v && !b, "R5 direct accept ignored", {30'd0, v, b}, 0);
    bread(17, rd); check(rd == 32'h04FF, "R5 flag kept", rd, 32'h04FF);
    accept(2'd2, 0, -1, v, d, b); check(v && d == RNMI, "R8 nmi rom", d, RNMI);
    accept(2'd3, 0, -1, v, d, b); check(v && d == RTRAP, "R8 trap rom", d, RTRAP);

    // enable and forward
    bwrite(0, 1);
    @(negedge clk); check(cpu_irq[1] == 1'b1, "R3 forward pulse", 32'(cpu_irq), 32'h2);
    @(negedge clk); check(cpu_irq[1] == 1'b0, "R3 single pulse", 32'(cpu_irq), 0);
    bread(1, rd); check(rd == 32'h2, "R3 ack set", rd, 32'h2);
    nb = 0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (cpu_irq[1]) nb++; end
    check(nb == 0, "R3 holdoff while ack set", 32'(nb), 0);
    bwrite(1, 32'h2);
    @(negedge clk); check(cpu_irq[1] == 1'b1, "R4 re-assert after w1c", 32'(cpu_irq), 32'h2);
    bread(1, rd); check(rd == 32'h2, "R4 ack set again", rd, 32'h2);

    accept(2'd0, 0, -1, v, d, b); check(v && d == tv(10), "R6 vector of line 10", d, tv(10));
    bread(17, rd); check(rd == 32'h00FF, "R6 flag cleared", rd, 32'h00FF);
    accept(2'd2, 0, -1, v, d, b); check(v && d == tv(100), "R8 nmi table", d, tv(100));
    accept(2'd3, 0, -1, v, d, b); check(v && d == tv(101), "R8 trap table", d, tv(101));

    // R9 busy window with a rejected accept inside it
    @(negedge clk); acc_req = 1'b1; acc_kind = 2'd2;
    @(negedge clk); acc_req = 1'b0;
    nb = 0; nv = 0;
    for (int i = 0; i < 12; i++) begin
      if (busy) nb++;
      if (vec_valid) nv++;
      if (i == 2) acc_req = 1'b1;
      if (i == 5) acc_req = 1'b0;
      @(negedge clk);
    end
    check(nb == 9, "R9 busy cycles", 32'(nb), 9);
    check(nv == 1, "R9 single vector while busy", 32'(nv), 1);

    // R6 priority table walk
    for (int r = 0; r < 6; r++) begin
      int a, bb, w, o;
      a = STIM[r][0]; bb = STIM[r][1]; w = STIM[r][2]; o = (a == w) ? bb : a;
      @(negedge clk); src_pulse[a] = 1'b1; src_pulse[bb] = 1'b1;
      @(negedge clk); src_pulse = '0;
      accept(2'd0, 0, -1, v, d, b); check(v && d == tv(w), "R6 winner", d, tv(w));
      accept(2'd0, 0, -1, v, d, b); check(v && d == tv(o), "R6 remaining", d, tv(o));
    end

    accept(2'd0, 0, -1, v, d, b); check(!v && !b, "R12 nothing pending", {30'd0, v, b}, 0);

    // R7 set wins over clear
    pulse_src(20);
    accept(2'd0, 0, 20, v, d, b); check(v && d == tv(20), "R7 vector", d, tv(20));
    bread(18, rd); check(rd == 32'h10FF, "R7 flag survives", rd, 32'h10FF);
    accept(2'd0, 0, -1, v, d, b); check(v && d == tv(20), "R7 drain", d, tv(20));

    // R10 direct lines
    @(negedge clk); dir_in[2] = 1'b1;
    @(negedge clk); dir_in = '0;
    check(cpu_irq[NGRP+2] == 1'b1, "R10 direct pass", 32'(cpu_irq), 32'h4000);
    @(negedge clk); check(cpu_irq[NGRP+2] == 1'b0, "R10 direct drop", 32'(cpu_irq), 0);
    accept(2'd1, 2, -1, v, d, b); check(v && d == tv(98), "R10 direct vector", d, tv(98));

    // R11 rewrite
    bwrite(128 + 98, 32'h5555_0001);
    accept(2'd1, 2, -1, v, d, b); check(v && d == 32'h5555_0001, "R11 rewritten entry", d, 32'h5555_0001);

    finish_run();
  end
endmodule